// File: doc/BRIEF.md
# Host-to-DSP Byte Mailbox Interface

This block joins an 8-bit host bus to a 16-bit DSP register bus through two independent mailboxes, one per direction. Each mailbox has a staging register on the writing side and a holding register on the reading side. A staged word crosses to the reading side by itself on the first clock edge at which the writer's empty flag is clear and the reader's full flag is clear. When the crossing happens, the reader's full flag sets and the writer's empty flag sets again. A writer cannot overwrite a word that has not yet crossed, and the reading side keeps its word until the reader takes it.

Besides data, the block carries a host command: a 5-bit vector plus a command bit, which the DSP sees as a pending flag. It passes two flag bits each way between the host control register and the DSP status register. It drives three level-sensitive DSP interrupt requests. Host reads have their effect in the cycle the read strobe is high. The read data is combinational from the registered state. Register contents change at the following rising edge.

Top module: `hmbx_top`

## Requirements
- R1: After synchronous reset the host status byte (host address 2) reads 0x02, the command register (address 1) reads 0x16, host control (address 0) reads 0x00 and the interrupt vector byte (address 3) reads 0x0F. The DSP control word (DSP address 0) reads 0x0000 and the DSP status word (DSP address 1) reads 0x0002. DSP status bit 7 (DMA) always reads 0.
- R2: A DSP write to DSP address 2 is taken only while DSP status bit 1 (transmit empty) is set, and clears that bit. The word then crosses when host status bit 0 (receive full) is clear. The high byte becomes readable at host address 6 and the low byte at host address 7, host bit 0 sets, and DSP bit 1 sets again. A DSP data write made while DSP bit 1 is clear is dropped.
- R3: A host write to address 6 (high byte) or 7 (low byte) is taken only while host status bit 1 (transmit empty) is set. The low-byte write clears that bit. The word then crosses to DSP address 2 when DSP status bit 0 (receive full) is clear, setting DSP bit 0 and host bit 1 again.
- R4: A host read of address 7 clears host status bit 0, and a DSP read of DSP address 2 clears DSP status bit 0. Either clear lets a word already staged in that direction cross. A staged word waits, unchanged, while the reading side is full.
- R5: A host read of address 6 or 7 while host bit 0 is clear returns the byte FILL_BYTE. A DSP data read while DSP bit 0 is clear returns FILL_WORD. Neither of these reads changes any flag.
- R6: The command register holds a vector in bits 4:0 and a command bit in bit 7, and bits 6:5 read 0. The command bit shows as DSP status bit 2 (command pending). Writing bit 7 as 0 clears it.
- R7: irq_rx equals DSP status bit 0 AND DSP control bit 0. irq_tx equals DSP status bit 1 AND control bit 1. irq_cmd equals DSP status bit 2 AND control bit 2.
- R8: DSP control bits 3 and 4 read back as host status bits 3 and 4. Host control bits 3 and 4 read back as DSP status bits 3 and 4. Host control keeps only bits 0, 1, 3 and 4, and its other bits read 0.
- R9: Host writes to address 2 and DSP writes to DSP address 1 are ignored. Host address 4 reads 0x00 and host address 5 reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host byte register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| dsp_addr | input | 2 | DSP register select: 0 control, 1 status, 2 data, 3 reads 0 |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe (read side effects) |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data, combinational |
| irq_rx | output | 1 | Receive-data interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_cmd | output | 1 | Host-command interrupt request |

## Verification
A stuck or wrongly set full or empty flag shows up at the ports quickly. One clock edge after a write, the status bytes on both buses are wrong, and the next data read returns the filler value where a real word was expected, or the other way round. A crossing that fires while the reader is still full overwrites its word, and the next data read returns a later word than the expected one. Writes that should be dropped are caught by reading back the older word that must have survived them. Broken flag mirroring or a wrong interrupt gate is visible in the same cycle as the status read or the interrupt outputs.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    localparam int HB    = 8;
    localparam int DW    = 2 * HB;
    localparam int VEC_W = 5;

    typedef enum logic [2:0] {
        HA_CTRL = 3'd0,
        HA_CVEC = 3'd1,
        HA_STAT = 3'd2,
        HA_IVEC = 3'd3,
        HA_ZERO = 3'd4,
        HA_RSVD = 3'd5,
        HA_DHI  = 3'd6,
        HA_DLO  = 3'd7
    } haddr_e;

    typedef enum logic [1:0] {
        DA_CTRL = 2'd0,
        DA_STAT = 2'd1,
        DA_DATA = 2'd2,
        DA_NONE = 2'd3
    } daddr_e;

    // DSP-side control word, bits 4..0
    typedef struct packed {
        logic flag_b;
        logic flag_a;
        logic cmd_ie;
        logic tx_ie;
        logic rx_ie;
    } dctrl_t;

    // Host-side control byte, stored bits only
    typedef struct packed {
        logic flag_b;
        logic flag_a;
        logic tx_req;
        logic rx_req;
    } hctrl_t;

    typedef struct packed {
        logic             cmd;
        logic [VEC_W-1:0] vec;
    } cvec_t;

    function automatic logic [HB-1:0] hctrl_byte(hctrl_t c);
        return {3'b000, c.flag_b, c.flag_a, 1'b0, c.tx_req, c.rx_req};
    endfunction

    function automatic hctrl_t hctrl_from(logic [HB-1:0] b);
        hctrl_t c;
        c.flag_b = b[4];
        c.flag_a = b[3];
        c.tx_req = b[1];
        c.rx_req = b[0];
        return c;
    endfunction

    function automatic logic [HB-1:0] cvec_byte(cvec_t v);
        return {v.cmd, {(HB-1-VEC_W){1'b0}}, v.vec};
    endfunction

    function automatic logic [HB-1:0] hstat_byte(dctrl_t d, logic txe, logic rxf);
        return {3'b000, d.flag_b, d.flag_a, 1'b0, txe, rxf};
    endfunction

    function automatic logic [DW-1:0] dstat_word(hctrl_t h, logic pend, logic txe, logic rxf);
        return {{(DW-8){1'b0}}, 1'b0, 2'b00, h.flag_b, h.flag_a, pend, txe, rxf};
    endfunction
endpackage

// File: rtl/hmbx_lane.sv
module hmbx_lane
    import hmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic          commit,
    input  logic [DW-1:0] wdata,
    input  logic          drain,
    output logic          src_empty,
    output logic          dst_full,
    output logic [DW-1:0] dst_word
);
    logic [DW-1:0] stage_q;
    logic [DW-1:0] dst_q;
    logic          empty_q;
    logic          full_q;
    logic          move;

    assign move = !empty_q && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            dst_q   <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            if (empty_q && wr_hi) stage_q[DW-1:HB] <= wdata[DW-1:HB];
            if (empty_q && wr_lo) stage_q[HB-1:0]  <= wdata[HB-1:0];
            if (move) begin
                dst_q   <= stage_q;
                full_q  <= 1'b1;
                empty_q <= 1'b1;
            end else begin
                if (empty_q && commit) empty_q <= 1'b0;
                if (full_q && drain)   full_q  <= 1'b0;
            end
        end
    end

    assign src_empty = empty_q;
    assign dst_full  = full_q;
    assign dst_word  = dst_q;

    assert_full_held_R4: assert property (@(posedge clk) disable iff (rst)
        (full_q && !drain) |=> (full_q && $stable(dst_q)));
    assert_stage_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!empty_q) |=> $stable(stage_q));
    assert_full_clear_by_read_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(drain));
    assert_cross_sets_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (!empty_q && !full_q) |=> (full_q && empty_q));
endmodule

// File: rtl/hmbx_ctl.sv
module hmbx_ctl
    import hmbx_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_RESET  = 5'h16,
    parameter logic [HB-1:0]    IVEC_RESET = 8'h0F
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hctrl,
    input  logic          wr_cvec,
    input  logic          wr_ivec,
    input  logic [HB-1:0] hdata,
    input  logic          wr_dctrl,
    input  logic [DW-1:0] ddata,
    input  logic          rx_full,
    input  logic          tx_empty,
    output hctrl_t        hctrl,
    output dctrl_t        dctrl,
    output cvec_t         cvec,
    output logic [HB-1:0] ivec,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          irq_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hctrl <= '0;
            dctrl <= '0;
            cvec  <= '{cmd: 1'b0, vec: VEC_RESET};
            ivec  <= IVEC_RESET;
        end else begin
            if (wr_hctrl) hctrl <= hctrl_from(hdata);
            if (wr_cvec) begin
                cvec.cmd <= hdata[HB-1];
                cvec.vec <= hdata[VEC_W-1:0];
            end
            if (wr_ivec)  ivec  <= hdata;
            if (wr_dctrl) dctrl <= dctrl_t'(ddata[4:0]);
        end
    end

    assign irq_rx  = rx_full  && dctrl.rx_ie;
    assign irq_tx  = tx_empty && dctrl.tx_ie;
    assign irq_cmd = cvec.cmd && dctrl.cmd_ie;

    assert_cvec_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_cvec |=> $stable(cvec));
    assert_dctrl_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_dctrl |=> $stable(dctrl));
    assert_hctrl_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_hctrl |=> $stable(hctrl));
endmodule

// File: rtl/hmbx_top.sv
module hmbx_top
    import hmbx_pkg::*;
#(
    parameter logic [HB-1:0] FILL_BYTE = 8'hE7,
    parameter logic [DW-1:0] FILL_WORD = 16'hC3C3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [1:0]    dsp_addr,
    input  logic          dsp_wr,
    input  logic          dsp_rd,
    input  logic [15:0]   dsp_wdata,
    output logic [15:0]   dsp_rdata,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          irq_cmd
);
    haddr_e ha;
    daddr_e da;
    assign ha = haddr_e'(host_addr);
    assign da = daddr_e'(dsp_addr);

    // DSP to host lane
    logic          d2h_empty, d2h_full;
    logic [DW-1:0] d2h_word;
    logic          dsp_data_wr;
    assign dsp_data_wr = dsp_wr && (da == DA_DATA);

    hmbx_lane u_d2h (
        .clk       (clk),
        .rst       (rst),
        .wr_hi     (dsp_data_wr),
        .wr_lo     (dsp_data_wr),
        .commit    (dsp_data_wr),
        .wdata     (dsp_wdata),
        .drain     (host_rd && (ha == HA_DLO)),
        .src_empty (d2h_empty),
        .dst_full  (d2h_full),
        .dst_word  (d2h_word)
    );

    // Host to DSP lane
    logic          h2d_empty, h2d_full;
    logic [DW-1:0] h2d_word;
    logic          host_lo_wr;
    assign host_lo_wr = host_wr && (ha == HA_DLO);

    hmbx_lane u_h2d (
        .clk       (clk),
        .rst       (rst),
        .wr_hi     (host_wr && (ha == HA_DHI)),
        .wr_lo     (host_lo_wr),
        .commit    (host_lo_wr),
        .wdata     ({host_wdata, host_wdata}),
        .drain     (dsp_rd && (da == DA_DATA)),
        .src_empty (h2d_empty),
        .dst_full  (h2d_full),
        .dst_word  (h2d_word)
    );

    hctrl_t        hctrl;
    dctrl_t        dctrl;
    cvec_t         cvec;
    logic [HB-1:0] ivec;

    hmbx_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_hctrl (host_wr && (ha == HA_CTRL)),
        .wr_cvec  (host_wr && (ha == HA_CVEC)),
        .wr_ivec  (host_wr && (ha == HA_IVEC)),
        .hdata    (host_wdata),
        .wr_dctrl (dsp_wr && (da == DA_CTRL)),
        .ddata    (dsp_wdata),
        .rx_full  (h2d_full),
        .tx_empty (d2h_empty),
        .hctrl    (hctrl),
        .dctrl    (dctrl),
        .cvec     (cvec),
        .ivec     (ivec),
        .irq_rx   (irq_rx),
        .irq_tx   (irq_tx),
        .irq_cmd  (irq_cmd)
    );

    always_comb begin
        case (ha)
            HA_CTRL: host_rdata = hctrl_byte(hctrl);
            HA_CVEC: host_rdata = cvec_byte(cvec);
            HA_STAT: host_rdata = hstat_byte(dctrl, h2d_empty, d2h_full);
            HA_IVEC: host_rdata = ivec;
            HA_ZERO: host_rdata = '0;
            HA_RSVD: host_rdata = '1;
            HA_DHI:  host_rdata = d2h_full ? d2h_word[DW-1:HB] : FILL_BYTE;
            default: host_rdata = d2h_full ? d2h_word[HB-1:0]  : FILL_BYTE;
        endcase
    end

    always_comb begin
        case (da)
            DA_CTRL: dsp_rdata = {{(DW-5){1'b0}}, dctrl};
            DA_STAT: dsp_rdata = dstat_word(hctrl, cvec.cmd, d2h_empty, h2d_full);
            DA_DATA: dsp_rdata = h2d_full ? h2d_word : FILL_WORD;
            default: dsp_rdata = '0;
        endcase
    end

    assert_irq_rx_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> (h2d_full && dctrl.rx_ie));
    assert_dma_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (da == DA_STAT) |-> (dsp_rdata[7] == 1'b0));
endmodule

// File: tb/sim_hmbx_top.sv
module sim_hmbx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  dsp_addr = '0;
    logic        dsp_wr = 1'b0, dsp_rd = 1'b0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;
    logic        irq_rx, irq_tx, irq_cmd;

    localparam logic [7:0]  FB = 8'hE7;
    localparam logic [15:0] FW = 16'hC3C3;

    always #10 clk = ~clk;

    hmbx_top u0 (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_addr(dsp_addr), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_cmd(irq_cmd)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    // scoreboard queues: kind 0 host byte, 1 dsp word, 2 irq vector {cmd,tx,rx}
    int          kind_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always begin
        @(negedge clk);
        #5;
        if (mon_on && exp_q.size() > 0) begin
            int          k;
            logic [15:0] e, got;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (k == 0)      got = {8'h00, host_rdata};
            else if (k == 1) got = dsp_rdata;
            else             got = {13'd0, irq_cmd, irq_tx, irq_rx};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s: got 0x%04h expected 0x%04h", t, got, e);
            end
        end
    end

    task automatic push(int k, logic [15:0] e, string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [2:0] a, logic [7:0] e, string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        push(0, {8'h00, e}, t);
        mon_on = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; mon_on = 1'b0;
    endtask

    task automatic dwrite(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        dsp_addr = a; dsp_wdata = d; dsp_wr = 1'b1;
        @(negedge clk);
        dsp_wr = 1'b0;
    endtask

    task automatic dread(logic [1:0] a, logic [15:0] e, string t);
        @(negedge clk);
        dsp_addr = a; dsp_rd = 1'b1;
        push(1, e, t);
        mon_on = 1'b1;
        @(negedge clk);
        dsp_rd = 1'b0; mon_on = 1'b0;
    endtask

    task automatic irqchk(logic [2:0] e, string t);
        @(negedge clk);
        dsp_addr = 2'd3; host_addr = 3'd4;
        push(2, {13'd0, e}, t);
        mon_on = 1'b1;
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        hread(3'd2, 8'h02, "R1 host status");
        hread(3'd1, 8'h16, "R1 command vector");
        hread(3'd0, 8'h00, "R1 host control");
        hread(3'd3, 8'h0F, "R1 int vector");
        dread(2'd0, 16'h0000, "R1 dsp control");
        dread(2'd1, 16'h0002, "R1 dsp status");
        // R5 filler reads, no flag change
        hread(3'd6, FB, "R5 filler high");
        hread(3'd7, FB, "R5 filler low");
        hread(3'd2, 8'h02, "R5 flags unchanged host");
        dread(2'd2, FW, "R5 filler word");
        dread(2'd1, 16'h0002, "R5 flags unchanged dsp");
        // R2 DSP to host
        dwrite(2'd2, 16'h1234);
        idle(2);
        hread(3'd2, 8'h03, "R2 host receive full");
        dread(2'd1, 16'h0002, "R2 transmit empty again");
        hread(3'd6, 8'h12, "R2 high byte");
        hread(3'd2, 8'h03, "R2 high read keeps full");
        hread(3'd7, 8'h34, "R2 low byte");
        hread(3'd2, 8'h02, "R4 low read clears full");
        // R4 backpressure, R2 dropped write
        dwrite(2'd2, 16'hA1A2);
        idle(2);
        dwrite(2'd2, 16'hB1B2);
        idle(2);
        dread(2'd1, 16'h0000, "R4 staged word waits");
        dwrite(2'd2, 16'hC1C2);
        hread(3'd7, 8'hA2, "R4 first word kept");
        idle(2);
        hread(3'd6, 8'hB1, "R4 pending crosses high");
        hread(3'd7, 8'hB2, "R2 dropped write low");
        idle(2);
        dread(2'd1, 16'h0002, "R2 idle after drain");
        // R3 host to DSP
        hwrite(3'd6, 8'h55);
        hwrite(3'd7, 8'h66);
        idle(2);
        dread(2'd1, 16'h0003, "R3 dsp receive full");
        hread(3'd2, 8'h02, "R3 host transmit empty again");
        dread(2'd2, 16'h5566, "R3 word");
        dread(2'd1, 16'h0002, "R4 dsp read clears full");
        hwrite(3'd6, 8'h11);
        hwrite(3'd7, 8'h22);
        idle(2);
        hwrite(3'd6, 8'h33);
        hwrite(3'd7, 8'h44);
        idle(2);
        hread(3'd2, 8'h00, "R3 host transmit busy");
        hwrite(3'd6, 8'h99);
        hwrite(3'd7, 8'h88);
        dread(2'd2, 16'h1122, "R4 first host word");
        idle(2);
        dread(2'd2, 16'h3344, "R3 busy writes dropped");
        // R8 flags
        dwrite(2'd0, 16'h0018);
        hread(3'd2, 8'h1A, "R8 dsp flags to host");
        hwrite(3'd0, 8'h1B);
        dread(2'd1, 16'h001A, "R8 host flags to dsp");
        hread(3'd0, 8'h1B, "R8 host control");
        hwrite(3'd0, 8'hFF);
        hread(3'd0, 8'h1B, "R8 control mask");
        hwrite(3'd0, 8'h1B);
        // R6 command
        hwrite(3'd1, 8'h85);
        hread(3'd1, 8'h85, "R6 command register");
        dread(2'd1, 16'h001E, "R6 command pending");
        hwrite(3'd1, 8'h05);
        dread(2'd1, 16'h001A, "R6 command cleared");
        // R7 interrupts
        dwrite(2'd0, 16'h0007);
        irqchk(3'b010, "R7 tx only");
        hwrite(3'd1, 8'h80);
        irqchk(3'b110, "R7 cmd and tx");
        hwrite(3'd6, 8'h12);
        hwrite(3'd7, 8'h34);
        idle(2);
        irqchk(3'b111, "R7 all");
        dwrite(2'd0, 16'h0000);
        irqchk(3'b000, "R7 disabled");
        dread(2'd2, 16'h1234, "R3 word under irq test");
        // R9 ignored writes
        hwrite(3'd2, 8'hFF);
        hread(3'd2, 8'h02, "R9 host status write ignored");
        hread(3'd4, 8'h00, "R9 address 4 zero");
        hread(3'd5, 8'hFF, "R9 address 5");
        dwrite(2'd1, 16'hFFFF);
        dread(2'd1, 16'h001E, "R9 dsp status write ignored");
        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule